// File: doc/BRIEF.md
# I2C Register-Pair Slave

This block is an I2C target that lets a bus host reach a bank of 8-bit registers kept outside it. A write transaction carries the device address once. After that it carries any number of (register address, data) byte pairs, and each pair may name any register, in any order. The block does not auto-increment: every data byte goes to the address byte that came just before it.

To read a register, the host first sends a short write holding one register address. It then issues a repeated START and the device address with the read bit set. The block returns the addressed register, MSB first, for as long as the host acknowledges. A not-acknowledge ends the read.

SCL and SDA pass through a two-flop synchronizer into the system clock. START, STOP and the SCL edges are detected on the synchronized copies. The register file sits outside the block and is reached through a one-cycle write strobe and an address/read-data pair.

Top module: `i2c_pair_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_pull` and `rf_we` are 0.
- R2: The 7-bit address field (bits 7..1) of the first byte after a START is compared with `DEV_ADDR` (default 7'h60). On a match the block holds SDA low for the whole of the ninth SCL clock. Bit 0 selects the direction: 0 means write, 1 means read.
- R3: On an address mismatch the block does not acknowledge. It then keeps SDA released and issues no write until the next START or STOP.
- R4: In a write transaction the bytes that follow the device address alternate strictly between register address and data. Each data byte is written to the address byte just before it. Pairs may repeat or jump between addresses without auto-increment.
- R5: Every register-address byte and data byte received in a write transaction is acknowledged.
- R6: Each data byte produces exactly one `rf_we` pulse, one system clock long. The pulse comes after the eighth data bit's SCL rise and before the block drives the ACK.
- R7: A STOP or repeated START that arrives between a register address and its data byte causes no write. The address is kept as the read pointer.
- R8: After a repeated START with read direction, the block shifts out the register named by the last register address, MSB first. Each bit changes only while SCL is low.
- R9: If the host acknowledges a read byte, the same register is sent again. If the host does not acknowledge, the block releases SDA and stays silent until the next START or STOP.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one releases SDA on the next clock.
- R11: `sda_pull` changes only after a detected SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| rf_we | output | 1 | Register-file write strobe, one clock |
| rf_addr | output | 8 | Register-file address (current pointer) |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data for `rf_addr` |

## Verification
The bench builds the block with its default parameters: device address 7'h60 and two synchronizer stages. With an SCL quarter-period of fifteen system clocks, the synchronizer delay falls well inside each SCL phase. Every edge, START and STOP therefore lands unambiguously. The default address lets mismatches be probed with addresses that differ only in the low bit and only in a high bit. The bench runs reads back to back after writes to the same registers, so overwrites within one transaction and the retained read pointer after an abandoned pair can both be observed.

// File: rtl/i2cps_pkg.sv
// Shared types and constants for the I2C register-pair slave.
// Assumes byte-wide register addresses and data.
package i2cps_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    // Bus phase of the byte engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_RACK
    } phase_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_DEV,
        K_REG,
        K_DAT
    } kind_t;
endpackage

// File: rtl/i2cps_sync.sv
// Multi-stage synchronizer for W asynchronous inputs.
// Assumes the inputs idle high (bus released) and resets to that level.
module i2cps_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // First stage captures the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage copies the stage before it
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= '1;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cps_cond.sv
// Detects SCL edges, START and STOP from the synchronized bus levels.
// Assumes SCL and SDA pass through synchronizers of equal depth.
module i2cps_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    // Hold the previous synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = !scl_q && scl_s;
    assign scl_fall = scl_q && !scl_s;
    assign start_ev = scl_q && scl_s && sda_q && !sda_s;
    assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/i2cps_engine.sv
// Byte engine: shifts bytes, matches the device address, acknowledges,
// alternates register address and data bytes, and serves reads.
// Assumes single-cycle event strobes from i2cps_cond.
module i2cps_engine
    import i2cps_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              sda_pull,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    phase_t            ph;
    kind_t             kind;
    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] shreg, txsh, ptr, wdata;
    logic              rw, we;

    // Bus state machine with its shift, pointer and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            kind     <= K_DEV;
            bcnt     <= '0;
            shreg    <= '0;
            txsh     <= '0;
            ptr      <= '0;
            wdata    <= '0;
            rw       <= 1'b0;
            we       <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            we <= 1'b0;
            if (start_ev) begin
                ph       <= PH_RX;
                kind     <= K_DEV;
                bcnt     <= '0;
                sda_pull <= 1'b0;
            end else if (stop_ev) begin
                ph       <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (ph)
                    PH_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            bcnt  <= bcnt + 1'b1;
                            if (kind == K_DAT && bcnt == LAST_BIT) begin
                                we    <= 1'b1;
                                wdata <= {shreg[BYTE_W-2:0], sda_s};
                            end
                        end else if (scl_fall && bcnt == FULL) begin
                            bcnt <= '0;
                            if (kind == K_DEV && shreg[BYTE_W-1:1] != DEV_ADDR) begin
                                ph <= PH_IDLE;
                            end else begin
                                ph       <= PH_ACK;
                                sda_pull <= 1'b1;
                                if (kind == K_DEV) rw  <= shreg[0];
                                if (kind == K_REG) ptr <= shreg;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            if (kind == K_DEV && rw) begin
                                ph       <= PH_TX;
                                sda_pull <= !rf_rdata[BYTE_W-1];
                                txsh     <= {rf_rdata[BYTE_W-2:0], 1'b0};
                            end else begin
                                ph       <= PH_RX;
                                sda_pull <= 1'b0;
                                kind     <= (kind == K_REG) ? K_DAT : K_REG;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bcnt == FULL) begin
                                ph       <= PH_RACK;
                                sda_pull <= 1'b0;
                                bcnt     <= '0;
                            end else begin
                                sda_pull <= !txsh[BYTE_W-1];
                                txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    PH_RACK: begin
                        if (scl_rise && sda_s) begin
                            ph <= PH_IDLE;
                        end else if (scl_fall) begin
                            ph       <= PH_TX;
                            sda_pull <= !rf_rdata[BYTE_W-1];
                            txsh     <= {rf_rdata[BYTE_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rf_we    = we;
    assign rf_addr  = ptr;
    assign rf_wdata = wdata;
endmodule

// File: rtl/i2c_pair_slave.sv
// Top of the I2C register-pair slave: synchronizer, bus-condition
// detector and byte engine. Assumes clk runs well above the SCL rate.
module i2c_pair_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic       rf_we,
    output logic [7:0] rf_addr,
    output logic [7:0] rf_wdata,
    input  logic [7:0] rf_rdata
);
    logic [1:0] bus_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    i2cps_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );

    i2cps_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (bus_s[1]),
        .sda_s    (bus_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cps_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (bus_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rf_rdata (rf_rdata),
        .sda_pull (sda_pull),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata)
    );
endmodule

// File: rtl/i2cps_chk.sv
// Property checker for i2c_pair_slave, attached by bind below.
// Observes the top ports and the event strobes between its submodules.
module i2cps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_pull,
    input logic       rf_we,
    input logic [7:0] rf_addr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !sda_pull && !rf_we);

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we);

    // R6
    we_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> $past(scl_rise));

    // R6
    we_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> !sda_pull);

    // R4
    we_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> $stable(rf_addr));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n) start_ev |=> !sda_pull);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> !sda_pull);

    // R11
    sda_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

bind i2c_pair_slave i2cps_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_pull (sda_pull),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr)
);

// File: tb/sim_i2c_pair_slave.sv
`timescale 1ns/1ps
// Scoreboard bench: bus tasks push expected writes, a monitor pops them.
module sim_i2c_pair_slave;
    localparam time Q = 60ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull, rf_we;
    logic [7:0] rf_addr, rf_wdata, rf_rdata;
    logic [7:0] mem [256];
    logic [15:0] exp_q [$];
    int         total = 0;
    int         bad = 0;
    logic       prev_we = 1'b0;
    wire        sda_line = m_sda && !sda_pull;

    always #2 clk = ~clk;

    i2c_pair_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 37) ^ 8'h5A;
    endfunction

    // Register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
        end
    end
    assign rf_rdata = mem[rf_addr];

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes and checks the strobe shape (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we) begin
                check(!prev_we, "R6 strobe longer than one clock", 1, 0);
                check(!sda_pull, "R6 strobe while ACK driven", 1, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R3/R7 unexpected write", {rf_addr, rf_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check({rf_addr, rf_wdata} == e, "R4 write pair", {rf_addr, rf_wdata}, e);
                end
            end
            prev_we <= rf_we;
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; #Q;
        m_sda = 1'b0; #Q;
        m_scl = 1'b0; #Q;
    endtask

    task automatic bus_restart();
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b0; #Q;
        m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b1; #Q;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q;
            m_scl = 1'b1; #Q;
            m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        ack = !sda_line;
        m_scl = 1'b0; #Q;
    endtask

    // Driver: sends one register pair and queues the expected write
    task automatic send_pair(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        wr_byte(a, ack);
        check(ack, "R5 ack on register address", ack, 1);
        exp_q.push_back({a, d});
        wr_byte(d, ack);
        check(ack, "R5 ack on data", ack, 1);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q;
            m_scl = 1'b1; #Q;
            b[i] = sda_line;
            m_scl = 1'b0;
        end
        #Q;
        m_sda = !mack; #Q;
        m_scl = 1'b1; #Q;
        m_scl = 1'b0; #Q;
        m_sda = 1'b1;
    endtask

    task automatic read_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic ack;
        logic [7:0] got;
        bus_start();
        wr_byte(8'hC0, ack);
        check(ack, "R2 ack on device address", ack, 1);
        wr_byte(a, ack);
        bus_restart();
        wr_byte(8'hC1, ack);
        check(ack, "R8 ack on read address", ack, 1);
        rd_byte(1'b0, got);
        check(got == exp, req, got, exp);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] got;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!sda_pull, "R1 sda_pull in reset", sda_pull, 0);
        check(!rf_we, "R1 rf_we in reset", rf_we, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!sda_pull && !rf_we, "R1 quiet after reset", {sda_pull, rf_we}, 0);

        // R2 R4 R5: random pairs, repeat of one address, no auto-increment
        bus_start();
        wr_byte(8'hC0, ack);
        check(ack, "R2 ack on matching address", ack, 1);
        send_pair(8'h10, 8'hA1);
        send_pair(8'h03, 8'h5C);
        send_pair(8'hF0, 8'h77);
        send_pair(8'h10, 8'h0E);
        bus_stop();
        #Q;
        check(exp_q.size() == 0, "R4 all pairs written", exp_q.size(), 0);
        check(mem[8'h11] == init_val(8'h11), "R4 no auto-increment", mem[8'h11], init_val(8'h11));

        // R3: mismatch in low and high address bits
        bus_start();
        wr_byte(8'hC2, ack);
        check(!ack, "R3 no ack for 61h", ack, 0);
        wr_byte(8'h22, ack);
        check(!ack, "R3 silent after mismatch", ack, 0);
        wr_byte(8'h33, ack);
        check(!ack, "R3 silent after mismatch", ack, 0);
        bus_stop();
        bus_start();
        wr_byte(8'h40, ack);
        check(!ack, "R3 no ack for 20h", ack, 0);
        bus_stop();
        #Q;
        check(mem[8'h22] == init_val(8'h22), "R3 no write", mem[8'h22], init_val(8'h22));

        // R7: address then STOP discards it
        bus_start();
        wr_byte(8'hC0, ack);
        wr_byte(8'h40, ack);
        check(ack, "R5 ack on lone address", ack, 1);
        bus_stop();
        #Q;
        check(mem[8'h40] == init_val(8'h40), "R7 no write on stop", mem[8'h40], init_val(8'h40));

        // R7 R8: address then repeated START keeps it as read pointer
        read_reg(8'h41, init_val(8'h41), "R7 R8 pointer kept, read data");
        check(mem[8'h41] == init_val(8'h41), "R7 no write on restart", mem[8'h41], init_val(8'h41));

        // R8 R9: read, host ACK repeats same register, NACK ends
        bus_start();
        wr_byte(8'hC0, ack);
        wr_byte(8'hF0, ack);
        bus_restart();
        wr_byte(8'hC1, ack);
        rd_byte(1'b1, got);
        check(got == 8'h77, "R8 read MSB first", got, 8'h77);
        rd_byte(1'b0, got);
        check(got == 8'h77, "R9 same register after host ack", got, 8'h77);
        rd_byte(1'b0, got);
        check(got == 8'hFF, "R9 released after nack", got, 8'hFF);
        bus_stop();

        // R4: last write to a repeated address wins
        read_reg(8'h10, 8'h0E, "R4 overwrite within transaction");
        read_reg(8'h03, 8'h5C, "R4 second pair");

        // R10: a new transaction right after reads still works
        bus_start();
        wr_byte(8'hC0, ack);
        check(ack, "R10 start detected again", ack, 1);
        send_pair(8'h88, 8'h3C);
        bus_stop();
        #Q;
        check(exp_q.size() == 0, "R4 final write landed", exp_q.size(), 0);
        check(mem[8'h88] == 8'h3C, "R4 final data", mem[8'h88], 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule